// File: doc/BRIEF.md
# DDR2 Write Lane Strobe and Data Slot Generator

This block drives one byte lane of a DDR2 write path from logic running at half the memory clock. Each half-rate cycle it hands a 4:1 output serializer four time slots, which are two memory clocks, of DQ data with a matching tristate nibble. It also hands over a DQS strobe nibble with its own tristate nibble. Slot 0 is serialized first. The controller raises `wr_arm_i` over the write window and raises `wr_load_i` on each cycle that a four-beat word is offered on `wdata_i`. One load cycle gives a burst of 4 and two load cycles give a burst of 8. `wr_arm_i` stays high for one cycle after the last load.

`odd_wl_i` chooses one of two slot alignments. When it is low, every burst word fills one whole nibble. When it is high, the burst is shifted by two slots, so each word is split across two consecutive cycles. The strobe is driven low for two slots before the first data slot and again for two slots after the last data slot. It toggles across the data slots and is released after the closing slots. Every slot that is not driven carries tristate 1 and data 0.

Top module: `wr_lane_gen`

## Requirements
- R1: After reset, and whenever no burst is in flight, `dq_tri_o` and `dqs_tri_o` are all ones and `dq_o` and `dqs_o` are all zeros. A slot whose tristate bit is 1 always carries data 0.
- R2: Each cycle with both `wr_arm_i` and `wr_load_i` high accepts one word of four beats, and the burst drives exactly four DQ slots per accepted word.
- R3: With `odd_wl_i` low, a word accepted in cycle t appears in cycle t+2, with beat b in slot b at `dq_o[b*8 +: 8]` and `dq_tri_o[b]` = 0.
- R4: With `odd_wl_i` high, beats 0 and 1 of a word accepted in cycle t appear in slots 2 and 3 of cycle t+2, and beats 2 and 3 appear in slots 0 and 1 of cycle t+3.
- R5: In every driven DQ slot s, the strobe is driven (`dqs_tri_o[s]` = 0) with value s modulo 2, so the nibble reads 0,1,0,1.
- R6: The two slots just before the first data slot of a burst drive the strobe low (preamble).
- R7: The two slots just after the last data slot drive the strobe low (postamble), and the strobe is released afterwards.
- R8: `wr_load_i` without `wr_arm_i`, or `wr_arm_i` without `wr_load_i`, drives no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_arm_i | input | 1 | Write window from the controller |
| wr_load_i | input | 1 | Offers a burst word this cycle |
| odd_wl_i | input | 1 | Selects the two-slot-shifted alignment |
| wdata_i | input | 32 | Four beats, beat b in bits [b*8 +: 8] |
| dq_o | output | 32 | DQ serializer data, slot s in bits [s*8 +: 8] |
| dq_tri_o | output | 4 | DQ tristate per slot, 1 = high impedance |
| dqs_o | output | 4 | DQS serializer data per slot |
| dqs_tri_o | output | 4 | DQS tristate per slot, 1 = high impedance |

## Verification
The assertions assume that `odd_wl_i` does not change from the first load of a burst until that burst's last strobe slot has gone out. They also assume that `wr_arm_i` falls one cycle after the last load, and that at least one fully idle cycle separates bursts, so that a preamble never overlaps the previous postamble. The stimulus keeps to these rules. Each burst ends with a fixed run of idle cycles that covers the three-cycle output drain, and `odd_wl_i` is changed only at the start of a burst, after that drain. The sweep covers both alignments, one to three load cycles and several data patterns. It also covers load and arm pulses that arrive alone.

// File: rtl/wr_lane_pkg.sv
package wr_lane_pkg;
  localparam int SLOTS = 4;
  localparam int HALF  = SLOTS / 2;
endpackage

// File: rtl/wr_lane_stage.sv
module wr_lane_stage
  import wr_lane_pkg::*;
#(
  parameter int DQ_W = 8,
  localparam int WORD_W = SLOTS * DQ_W,
  localparam int HI_W   = HALF * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              v1_o,
  output logic [WORD_W-1:0] d1_o,
  output logic              v2_o,
  output logic [HI_W-1:0]   d2_hi_o
);
  // second stage keeps only the beats that spill into the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_o    <= 1'b0;
      d1_o    <= '0;
      v2_o    <= 1'b0;
      d2_hi_o <= '0;
    end else begin
      v1_o    <= take_i;
      d1_o    <= take_i ? word_i : '0;
      v2_o    <= v1_o;
      d2_hi_o <= d1_o[WORD_W-1 -: HI_W];
    end
  end
endmodule

// File: rtl/wr_lane_slot.sv
module wr_lane_slot #(
  parameter int DQ_W = 8,
  parameter bit SVAL = 1'b0
) (
  input  logic            odd_i,
  input  logic            v_even_i,
  input  logic            v_odd_i,
  input  logic            amb_even_i,
  input  logic            amb_odd_i,
  input  logic [DQ_W-1:0] beat_even_i,
  input  logic [DQ_W-1:0] beat_odd_i,
  output logic [DQ_W-1:0] dq_o,
  output logic            dq_tri_o,
  output logic            dqs_o,
  output logic            dqs_tri_o
);
  logic            drive;
  logic            amble;
  logic [DQ_W-1:0] beat;

  always_comb begin
    drive = odd_i ? v_odd_i    : v_even_i;
    amble = odd_i ? amb_odd_i  : amb_even_i;
    beat  = odd_i ? beat_odd_i : beat_even_i;
    dq_o      = drive ? beat : '0;
    dq_tri_o  = ~drive;
    dqs_o     = drive & SVAL;
    dqs_tri_o = ~(drive | amble);
  end
endmodule

// File: rtl/wr_lane_gen.sv
module wr_lane_gen
  import wr_lane_pkg::*;
#(
  parameter int DQ_W = 8,
  localparam int WORD_W = SLOTS * DQ_W,
  localparam int HI_W   = HALF * DQ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_arm_i,
  input  logic              wr_load_i,
  input  logic              odd_wl_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] dq_o,
  output logic [SLOTS-1:0]  dq_tri_o,
  output logic [SLOTS-1:0]  dqs_o,
  output logic [SLOTS-1:0]  dqs_tri_o
);
  logic              take;
  logic              v1, v2;
  logic [WORD_W-1:0] d1;
  logic [HI_W-1:0]   d2_hi;
  logic              pre_even, post_even, pre_odd, post_odd;

  logic [WORD_W-1:0] dq_nxt;
  logic [SLOTS-1:0]  dq_tri_nxt, dqs_nxt, dqs_tri_nxt;

  assign take = wr_arm_i & wr_load_i;

  wr_lane_stage #(.DQ_W(DQ_W)) i_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take),
    .word_i  (wdata_i),
    .v1_o    (v1),
    .d1_o    (d1),
    .v2_o    (v2),
    .d2_hi_o (d2_hi)
  );

  // amble triggers: even lane opens on the load cycle, odd lane one cycle later
  assign pre_even  = take & ~v1;
  assign post_even = v2 & ~v1;
  assign pre_odd   = v1 & ~v2;
  assign post_odd  = v2 & ~v1;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic            v_odd, amb_even, amb_odd;
    logic [DQ_W-1:0] beat_odd;
    if (g < HALF) begin : g_lo
      assign v_odd    = v2;
      assign amb_even = post_even;
      assign amb_odd  = pre_odd;
      assign beat_odd = d2_hi[g*DQ_W +: DQ_W];
    end else begin : g_hi
      assign v_odd    = v1;
      assign amb_even = pre_even;
      assign amb_odd  = post_odd;
      assign beat_odd = d1[(g-HALF)*DQ_W +: DQ_W];
    end

    wr_lane_slot #(.DQ_W(DQ_W), .SVAL(g % 2 == 1)) i_slot (
      .odd_i       (odd_wl_i),
      .v_even_i    (v1),
      .v_odd_i     (v_odd),
      .amb_even_i  (amb_even),
      .amb_odd_i   (amb_odd),
      .beat_even_i (d1[g*DQ_W +: DQ_W]),
      .beat_odd_i  (beat_odd),
      .dq_o        (dq_nxt[g*DQ_W +: DQ_W]),
      .dq_tri_o    (dq_tri_nxt[g]),
      .dqs_o       (dqs_nxt[g]),
      .dqs_tri_o   (dqs_tri_nxt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o      <= '0;
      dq_tri_o  <= '1;
      dqs_o     <= '0;
      dqs_tri_o <= '1;
    end else begin
      dq_o      <= dq_nxt;
      dq_tri_o  <= dq_tri_nxt;
      dqs_o     <= dqs_nxt;
      dqs_tri_o <= dqs_tri_nxt;
    end
  end
endmodule

// File: rtl/wr_lane_gen_chk.sv
module wr_lane_gen_chk
  import wr_lane_pkg::*;
#(
  parameter int DQ_W = 8,
  localparam int WORD_W = SLOTS * DQ_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_arm_i,
  input logic              odd_wl_i,
  input logic [WORD_W-1:0] dq_o,
  input logic [SLOTS-1:0]  dq_tri_o,
  input logic [SLOTS-1:0]  dqs_o,
  input logic [SLOTS-1:0]  dqs_tri_o
);
  logic [WORD_W-1:0] rel_mask;
  always_comb begin
    for (int i = 0; i < SLOTS; i++) rel_mask[i*DQ_W +: DQ_W] = {DQ_W{dq_tri_o[i]}};
  end

  // R1
  released_dq_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_o & rel_mask) == '0);

  // R1
  released_strobe_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dqs_o & dqs_tri_o) == '0);

  // R5
  strobe_covers_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~dq_tri_o & dqs_tri_o) == '0);

  // R6
  even_preamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!odd_wl_i && $past(!odd_wl_i) && $past(&dq_tri_o) && !dq_tri_o[0])
      |-> $past(dqs_tri_o[3:2] == 2'b00));

  // R7
  odd_postamble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (odd_wl_i && !dq_tri_o[1] && dq_tri_o[2])
      |-> (dqs_tri_o[3:2] == 2'b00 && dqs_o[3:2] == 2'b00));

  // R4
  odd_pairing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_wl_i |-> (dq_tri_o[0] == dq_tri_o[1] && dq_tri_o[2] == dq_tri_o[3]));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_arm_i && !$past(wr_arm_i) && !$past(wr_arm_i, 2) && !$past(wr_arm_i, 3))
      |-> (&dq_tri_o && &dqs_tri_o));
endmodule

bind wr_lane_gen wr_lane_gen_chk #(.DQ_W(DQ_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_arm_i  (wr_arm_i),
  .odd_wl_i  (odd_wl_i),
  .dq_o      (dq_o),
  .dq_tri_o  (dq_tri_o),
  .dqs_o     (dqs_o),
  .dqs_tri_o (dqs_tri_o)
);

// File: tb/test_wr_lane_gen.sv
`timescale 1ns/1ps
module test_wr_lane_gen;
  localparam int W  = 8;
  localparam int S  = 4;
  localparam int NC = 512;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_arm_i = 1'b0, wr_load_i = 1'b0, odd_wl_i = 1'b0;
  logic [S*W-1:0] wdata_i = '0;
  logic [S*W-1:0] dq_o;
  logic [S-1:0]   dq_tri_o, dqs_o, dqs_tri_o;

  logic [S*W-1:0] e_dq [NC];
  logic [S-1:0]   e_dt [NC];
  logic [S-1:0]   e_s  [NC];
  logic [S-1:0]   e_st [NC];
  string          e_tag  [NC];
  string          e_stag [NC];

  int cyc = 0, checks = 0, errors = 0, drv_cnt = 0, bid = 0;

  always #4 clk = ~clk;

  wr_lane_gen #(.DQ_W(W)) i_wr_lane_gen (
    .clk_i(clk), .rst_ni(rst_ni), .wr_arm_i(wr_arm_i), .wr_load_i(wr_load_i),
    .odd_wl_i(odd_wl_i), .wdata_i(wdata_i), .dq_o(dq_o), .dq_tri_o(dq_tri_o),
    .dqs_o(dqs_o), .dqs_tri_o(dqs_tri_o)
  );

  function automatic logic [W-1:0] bval(int id, int b, int pat);
    case (pat)
      0: return W'(id * 37 + b * 11 + 1);
      1: return '1;
      default: return (b % 2 == 0) ? W'(8'hA5) : W'(8'h5A);
    endcase
  endfunction

  task automatic put_dq(int sl, logic [W-1:0] v, string tg);
    int c = sl / S;
    int s = sl % S;
    if (c >= NC) return;
    e_dq[c][s*W +: W] = v;
    e_dt[c][s] = 1'b0;
    e_s[c][s]  = s[0];
    e_st[c][s] = 1'b0;
    e_tag[c]   = tg;
    if (e_stag[c] == "R1") e_stag[c] = "R5";
  endtask

  task automatic put_amb(int sl, string tg);
    int c = sl / S;
    int s = sl % S;
    if (c >= NC) return;
    e_s[c][s]  = 1'b0;
    e_st[c][s] = 1'b0;
    e_stag[c]  = tg;
  endtask

  task automatic step(logic arm, logic load, logic [S*W-1:0] d);
    @(negedge clk);
    checks++;
    if (dq_o !== e_dq[cyc] || dq_tri_o !== e_dt[cyc]) begin
      errors++;
      $display("FAIL %s cycle %0d: dq %h tri %b, expected dq %h tri %b",
               e_tag[cyc], cyc, dq_o, dq_tri_o, e_dq[cyc], e_dt[cyc]);
    end
    checks++;
    if (dqs_o !== e_s[cyc] || dqs_tri_o !== e_st[cyc]) begin
      errors++;
      $display("FAIL %s cycle %0d: dqs %b tri %b, expected dqs %b tri %b",
               e_stag[cyc], cyc, dqs_o, dqs_tri_o, e_s[cyc], e_st[cyc]);
    end
    for (int i = 0; i < S; i++) if (!dq_tri_o[i]) drv_cnt++;
    wr_arm_i  = arm;
    wr_load_i = load;
    wdata_i   = d;
    if (cyc < NC - 1) cyc++;
  endtask

  // R2 R3 R4 R5 R6 R7: one burst of k words
  task automatic burst(logic odd, int k, int pat);
    int t0, s0;
    logic [S*W-1:0] w;
    odd_wl_i = odd;
    step(1'b0, 1'b0, '0);
    t0 = cyc;
    s0 = S * (t0 + 2) + 2 * int'(odd);
    for (int b = 0; b < S * k; b++) put_dq(s0 + b, bval(bid, b, pat), odd ? "R4" : "R3");
    put_amb(s0 - 2, "R6");
    put_amb(s0 - 1, "R6");
    put_amb(s0 + S * k, "R7");
    put_amb(s0 + S * k + 1, "R7");
    drv_cnt = 0;
    for (int j = 0; j < k; j++) begin
      for (int b = 0; b < S; b++) w[b*W +: W] = bval(bid, j * S + b, pat);
      step(1'b1, 1'b1, w);
    end
    step(1'b1, 1'b0, '0);
    repeat (4) step(1'b0, 1'b0, '0);
    checks++;
    if (drv_cnt != S * k) begin
      errors++;
      $display("FAIL R2 burst %0d: driven slots %0d, expected %0d", bid, drv_cnt, S * k);
    end
    bid++;
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin
      e_dq[i] = '0; e_dt[i] = '1; e_s[i] = '0; e_st[i] = '1;
      e_tag[i] = "R1"; e_stag[i] = "R1";
    end
    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (dq_o !== '0 || dq_tri_o !== '1 || dqs_o !== '0 || dqs_tri_o !== '1) begin
      errors++;
      $display("FAIL R1 reset: dq %h tri %b dqs %b stri %b, expected 0 1111 0000 1111",
               dq_o, dq_tri_o, dqs_o, dqs_tri_o);
    end
    rst_ni = 1'b1;
    repeat (2) step(1'b0, 1'b0, '0);

    for (int m = 0; m < 2; m++)
      for (int k = 1; k <= 3; k++)
        for (int p = 0; p < 3; p++)
          burst(m[0], k, p);

    // R8: load without arm, arm without load
    odd_wl_i = 1'b0;
    step(1'b0, 1'b0, '0);
    for (int i = cyc; i < cyc + 10 && i < NC; i++) begin
      e_tag[i] = "R8"; e_stag[i] = "R8";
    end
    drv_cnt = 0;
    step(1'b0, 1'b1, {S{8'h3C}});
    step(1'b0, 1'b1, {S{8'hC3}});
    step(1'b1, 1'b0, {S{8'h77}});
    step(1'b0, 1'b1, {S{8'h11}});
    repeat (5) step(1'b0, 1'b0, '0);
    checks++;
    if (drv_cnt != 0) begin
      errors++;
      $display("FAIL R8: driven slots %0d, expected 0", drv_cnt);
    end

    // one more burst after the ignored stimulus
    burst(1'b1, 2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: run still active, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule